// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Aggregator

This block gathers the per-endpoint event pulses of a USB device controller's protocol engine into one word of sticky flags and turns them into two level interrupt lines, one high priority and one low priority. The controller has sixteen logical endpoints. Each logical endpoint has a receive half and a transmit half, and each half owns one flag. A receive flag records a packet taken in without error. A transmit flag records a packet sent successfully, or a NAK handshake when interrupt-on-NAK is enabled for that endpoint. Endpoints that the `ISO_EP` parameter marks as isochronous never set a flag, because their traffic is serviced through the frame interrupt.

The CPU reaches the block through a small register bus with an address, a write strobe and a combinational read port. It reads the flag word and acknowledges flags by writing ones to a clear register. It sets a per-endpoint enable mask, a per-endpoint fast mask and a per-endpoint NAK-interrupt enable. A write-only routing register selects the line for the frame interrupt and for the fast endpoints.

Register map (3-bit word address): 0 flag word (read only), 1 clear (write only), 2 enable mask, 3 fast mask, 4 NAK-interrupt enable (bit n is logical endpoint n), 5 routing (write only; bit 0 frame, bit 1 fast).

Top module: `usb_ep_irq_status`

## Requirements
- R1: After reset the flag word, enable mask, fast mask, NAK enable and routing are all zero, and both interrupt lines are low.
- R2: A pulse on `rx_ok[n]` sets flag bit 2n at the next clock edge, and the bit stays set until cleared.
- R3: A pulse on `tx_done[n]` sets flag bit 2n+1 at the next clock edge.
- R4: A pulse on `nak_sent[n]` sets flag bit 2n+1 only when bit n of the NAK-enable register (address 4) is 1. Otherwise it leaves the bit unchanged.
- R5: Flags of endpoints marked in `ISO_EP` never set. With the default value, which marks endpoint 3, bits 6 and 7 always read 0.
- R6: Writing to address 1 clears every flag whose data bit is 1 and leaves the other flags unchanged. When a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: A flag reaches an interrupt line only when its bit in the enable mask (address 2) is 1. Flags are recorded whether or not they are enabled.
- R8: When routing bit 1 is 0, every enabled flag drives `irq_lo`, and no flag drives `irq_hi`, whatever the fast mask holds.
- R9: When routing bit 1 is 1, enabled flags whose fast-mask bit (address 3) is 1 drive `irq_hi`, and the other enabled flags drive `irq_lo`.
- R10: A `frame_tick` pulse raises `irq_hi` for one cycle, starting at the next edge, when routing bit 0 is 1. When routing bit 0 is 0 it raises `irq_lo` instead.
- R11: The interrupt lines are registered. They change one clock edge after the flag word changes.
- R12: The clear and routing registers read as zero, and a write to address 0 leaves the flag word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_ok | input | NUM_EP | Per-endpoint pulse: packet received without error |
| tx_done | input | NUM_EP | Per-endpoint pulse: packet transmitted |
| nak_sent | input | NUM_EP | Per-endpoint pulse: NAK handshake sent |
| frame_tick | input | 1 | Start-of-frame pulse |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 2*NUM_EP | Write data |
| reg_rdata | output | 2*NUM_EP | Read data for `reg_addr` (combinational) |
| irq_hi | output | 1 | High-priority interrupt line |
| irq_lo | output | 1 | Low-priority interrupt line |

## Verification
Every cycle, the assertions check the following. A receive or transmit pulse on a non-isochronous endpoint shows up in the flag word one edge later. A NAK with its enable off leaves the transmit flag alone. The isochronous bits stay zero. A clear without a competing event drops the bit. A line stays low when nothing enabled is pending. `irq_hi` stays low when fast routing is off and no routed frame tick is present. Only the directed scenarios can show the rest: the routing split between the two lines, the one-cycle frame pulse, set-beats-clear in a collision, the read-as-zero registers, and the exact one-cycle lag of the lines behind the flags.

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status #(
  parameter int NUM_EP = 16,
  parameter logic [NUM_EP-1:0] ISO_EP = 16'h0008
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EP-1:0]     rx_ok,
  input  logic [NUM_EP-1:0]     tx_done,
  input  logic [NUM_EP-1:0]     nak_sent,
  input  logic                  frame_tick,
  input  logic [2:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic [2*NUM_EP-1:0]   reg_wdata,
  output logic [2*NUM_EP-1:0]   reg_rdata,
  output logic                  irq_hi,
  output logic                  irq_lo
);
  localparam int W = 2 * NUM_EP;
  localparam logic [2:0] A_STAT  = 3'd0;
  localparam logic [2:0] A_CLR   = 3'd1;
  localparam logic [2:0] A_EN    = 3'd2;
  localparam logic [2:0] A_FAST  = 3'd3;
  localparam logic [2:0] A_NAKEN = 3'd4;
  localparam logic [2:0] A_ROUTE = 3'd5;

  logic [W-1:0]      stat_q, en_q, fast_q, set_v, clr_v, act_v;
  logic [NUM_EP-1:0] naken_q;
  logic [1:0]        route_q;

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    if (ISO_EP[n]) begin : g_iso
      assign set_v[2*n+1:2*n] = 2'b00;
    end else begin : g_bulk
      assign set_v[2*n]   = rx_ok[n];
      assign set_v[2*n+1] = tx_done[n] | (nak_sent[n] & naken_q[n]);
    end
  end

  assign clr_v = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;
  assign act_v = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      fast_q  <= '0;
      naken_q <= '0;
      route_q <= '0;
      irq_hi  <= 1'b0;
      irq_lo  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (reg_wr) begin
        case (reg_addr)
          A_EN:    en_q    <= reg_wdata;
          A_FAST:  fast_q  <= reg_wdata;
          A_NAKEN: naken_q <= reg_wdata[NUM_EP-1:0];
          A_ROUTE: route_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
      irq_hi <= (route_q[1] & |(act_v & fast_q)) | (frame_tick & route_q[0]);
      irq_lo <= (route_q[1] ? |(act_v & ~fast_q) : |act_v) | (frame_tick & ~route_q[0]);
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat_q;
      A_EN:    reg_rdata = en_q;
      A_FAST:  reg_rdata = fast_q;
      A_NAKEN: reg_rdata = {{(W-NUM_EP){1'b0}}, naken_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module usb_ep_irq_status_chk #(
  parameter int NUM_EP = 16,
  parameter logic [NUM_EP-1:0] ISO_EP = 16'h0008
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EP-1:0]   rx_ok,
  input logic [NUM_EP-1:0]   tx_done,
  input logic [NUM_EP-1:0]   nak_sent,
  input logic                frame_tick,
  input logic [2:0]          reg_addr,
  input logic                reg_wr,
  input logic [2*NUM_EP-1:0] reg_wdata,
  input logic [2*NUM_EP-1:0] stat_q,
  input logic [2*NUM_EP-1:0] en_q,
  input logic [NUM_EP-1:0]   naken_q,
  input logic [1:0]          route_q,
  input logic                irq_hi,
  input logic                irq_lo
);
  for (genvar n = 0; n < NUM_EP; n++) begin : g_chk
    if (ISO_EP[n]) begin : g_iso
      AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[2*n+1:2*n] == 2'b00); // R5
    end else begin : g_bulk
      AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok[n] |=> stat_q[2*n]); // R2
      AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done[n] |=> stat_q[2*n+1]); // R3
      AST_NAK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_sent[n] && !naken_q[n] && !tx_done[n] && !stat_q[2*n+1]
         && !(reg_wr && reg_addr == 3'd4)) |=> !stat_q[2*n+1]); // R4
      AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && reg_wdata[2*n] && !rx_ok[n]) |=> !stat_q[2*n]); // R6
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0 && !frame_tick) |=> (!irq_hi && !irq_lo)); // R7
  AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_q[1] && !(frame_tick && route_q[0])) |=> !irq_hi); // R8
endmodule

bind usb_ep_irq_status usb_ep_irq_status_chk #(.NUM_EP(NUM_EP), .ISO_EP(ISO_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ok(rx_ok), .tx_done(tx_done), .nak_sent(nak_sent),
  .frame_tick(frame_tick), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .stat_q(stat_q), .en_q(en_q), .naken_q(naken_q), .route_q(route_q),
  .irq_hi(irq_hi), .irq_lo(irq_lo)
);

// File: tb/usb_ep_irq_status_test.sv
module usb_ep_irq_status_test;
  localparam int N = 16;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] rx_ok = '0, tx_done = '0, nak_sent = '0;
  logic frame_tick = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic irq_hi, irq_lo;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  usb_ep_irq_status uut (
    .clk(clk), .rst_n(rst_n), .rx_ok(rx_ok), .tx_done(tx_done), .nak_sent(nak_sent),
    .frame_tick(frame_tick), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse(logic [N-1:0] r, logic [N-1:0] t, logic [N-1:0] k);
    @(negedge clk); rx_ok = r; tx_done = t; nak_sent = k;
    @(negedge clk); rx_ok = '0; tx_done = '0; nak_sent = '0;
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d); chk("R1 reg zero", d, '0);
    end
    chk("R1 irq_hi", {31'b0, irq_hi}, 0);
    chk("R1 irq_lo", {31'b0, irq_lo}, 0);
  endtask

  task automatic t_rx_tx;
    logic [W-1:0] d;
    pulse(16'h0001, '0, '0);
    rd(0, d); chk("R2 rx ep0", d, 32'h1);
    pulse(16'h8000, 16'h0004, '0);
    rd(0, d); chk("R2 R3 rx ep15 tx ep2", d, 32'h4000_0021);
    repeat (3) @(negedge clk);
    rd(0, d); chk("R2 sticky", d, 32'h4000_0021);
    wr(1, '1);
  endtask

  task automatic t_nak;
    logic [W-1:0] d;
    pulse('0, '0, 16'h0002);
    rd(0, d); chk("R4 nak disabled", d, '0);
    wr(4, 32'h0002);
    rd(4, d); chk("R4 naken readback", d, 32'h2);
    pulse('0, '0, 16'h0006);
    rd(0, d); chk("R4 nak enabled ep1 only", d, 32'h8);
    wr(1, '1);
  endtask

  task automatic t_iso;
    logic [W-1:0] d;
    wr(4, 32'hffff);
    pulse(16'h0008, 16'h0008, 16'h0008);
    rd(0, d); chk("R5 iso bits quiet", d, '0);
    wr(4, 0);
  endtask

  task automatic t_clear;
    logic [W-1:0] d;
    pulse(16'h0003, '0, '0);
    rd(0, d); chk("R6 setup", d, 32'h5);
    @(negedge clk); rx_ok = 16'h0002; reg_addr = 1; reg_wdata = 32'h5; reg_wr = 1'b1;
    @(negedge clk); rx_ok = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(0, d); chk("R6 set beats clear", d, 32'h4);
    wr(1, 32'h1);
    rd(0, d); chk("R6 zero bits untouched", d, 32'h4);
    wr(0, '0);
    rd(0, d); chk("R12 status not writable", d, 32'h4);
    rd(1, d); chk("R12 clear reads zero", d, '0);
    wr(1, '1);
  endtask

  task automatic t_mask;
    logic [W-1:0] d;
    pulse(16'h0001, '0, '0);
    @(negedge clk);
    chk("R7 disabled no irq", {31'b0, irq_lo}, 0);
    rd(0, d); chk("R7 still recorded", d, 32'h1);
    wr(2, 32'h1);
    chk("R11 lag after enable", {31'b0, irq_lo}, 0);
    @(negedge clk);
    chk("R7 enabled irq_lo", {31'b0, irq_lo}, 1);
    wr(1, '1);
    @(negedge clk);
    chk("R11 drops after clear", {31'b0, irq_lo}, 0);
  endtask

  task automatic t_route;
    logic [W-1:0] d;
    wr(2, '1); wr(3, 32'h1); wr(5, 32'h2);
    rd(5, d); chk("R12 route reads zero", d, '0);
    pulse(16'h0001, '0, '0);
    chk("R11 hi not yet", {31'b0, irq_hi}, 0);
    @(negedge clk);
    chk("R9 fast to hi", {30'b0, irq_hi, irq_lo}, 2'b10);
    pulse(16'h0002, '0, '0);
    @(negedge clk);
    chk("R9 slow to lo", {30'b0, irq_hi, irq_lo}, 2'b11);
    wr(5, 0);
    @(negedge clk);
    chk("R8 all low", {30'b0, irq_hi, irq_lo}, 2'b01);
    wr(1, '1); wr(2, 0); wr(3, 0);
    @(negedge clk);
  endtask

  task automatic t_frame;
    wr(5, 32'h1);
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    chk("R10 frame to hi", {30'b0, irq_hi, irq_lo}, 2'b10);
    @(negedge clk);
    chk("R10 frame one cycle", {30'b0, irq_hi, irq_lo}, 2'b00);
    wr(5, 0);
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    chk("R10 frame to lo", {30'b0, irq_hi, irq_lo}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_rx_tx; t_nak; t_iso; t_clear; t_mask; t_route; t_frame;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule